// File: doc/BRIEF.md
# Configurable SPI master shift engine

This block is the serial engine on the master side of an SPI link. A parallel write of a data word starts a frame. The engine then generates the serial clock from the system clock. It shifts the word out on MOSI and collects the same number of bits from MISO. When the frame ends it keeps the received word, right-aligned, for readback, and it pulses a completion strobe for one cycle. The chip-select line is driven by logic outside this block.

The configuration inputs set five things: the frame size (8 to 16 bits), the clock polarity, the clock phase, the bit order, and the serial clock period counted in system clocks. The engine copies the configuration when it accepts a write, so changes made to the configuration during a frame have no effect on that frame.

The control is a three-state machine. **IDLE** holds SCK at the idle level and waits for a write. The transition *start* (a write is accepted) enters **RUN**, which produces the SCK edges. The transition *last-edge* (the final SCK edge of the frame) enters **FINISH**, which lasts one cycle. From FINISH, the transition *restart* (a write arrives in that cycle) goes straight back to RUN, and the transition *retire* (no write) goes back to IDLE.

Top module: `spi_shift_master`

## Requirements
- R1: Frame size N follows from the length-enable and the 4-bit length code. When length-enable is 0, N is 8. When length-enable is 1, codes 4'b1000 to 4'b1111 give 8 to 15 bits, 4'b0000 gives 16 bits, and codes 4'b0001 to 4'b0111 give 8 bits.
- R2: Outside a frame, SCK sits at the polarity input: low for 0, high for 1. A frame makes exactly 2N SCK edges. Consecutive edges are D/2 system clocks apart, and the first edge comes D/2 clocks after the write is accepted. D is the divider input with bit 0 cleared, and any divider value below 8 counts as 8.
- R3: With phase 0, the first MOSI bit is present from the start of the frame. MISO is sampled on leading edges and MOSI changes on trailing edges. With phase 1, MOSI changes on leading edges (the first bit is already present at the first edge) and MISO is sampled on trailing edges. The leading edge is the rising edge for polarity 0 and the falling edge for polarity 1.
- R4: With bit-order 0, the N data bits go out and come in most significant first. With bit-order 1 they go least significant first. Data bits at or above position N are not sent.
- R5: The received word is right-aligned in the 16-bit readback, and bits N and above read 0. The readback keeps its value from one completion until the next completion.
- R6: busy is 1 from the cycle after an accepted write through the last SCK edge. done is high for exactly one cycle, in the cycle N·D system clocks after the accepting clock edge. busy and done are never high together.
- R7: A write presented while busy is 1 is ignored: the frame in progress still sends the original data, and its timing does not change.
- R8: While reset is asserted, SCK, busy and done are 0 and the readback is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_len_en | input | 1 | 0: 8-bit frames; 1: the length code sets the frame size |
| cfg_len_code | input | 4 | Frame-length code (0000 means 16 bits) |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on the leading edge; 1: sample on the trailing edge |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_div | input | 8 | System clocks per SCK period |
| wr_en | input | 1 | Write strobe for the transmit word; starts a frame |
| wr_data | input | 16 | Transmit word (right-aligned) |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion strobe |
| rx_data | output | 16 | Received word, right-aligned |

## Verification
The bench drives a write on a falling clock edge and then counts system clocks, sampling on every falling edge. It expects SCK edge k (counting from 0) D/2·(k+1) clocks after the accepting edge, and done together with the new readback exactly N·D clocks after that edge. It expects done to be low again one clock later. An arithmetic slave model captures MOSI on the sampling edge type and changes MISO on the other edge type. This uses the half period of slack between the two edge types, so the design's sampling point never coincides with a change on MISO.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RUN,
        S_FINISH
    } spi_state_e;

    // Frame size from length-enable and 4-bit code (R1)
    function automatic logic [4:0] frame_bits(input logic len_en, input logic [3:0] code);
        logic [4:0] n;
        if (!len_en)
            n = 5'd8;
        else if (code == 4'b0000)
            n = 5'd16;
        else if (code[3])
            n = {1'b0, code};
        else
            n = 5'd8;
        return n;
    endfunction

endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [DIV_W-2:0] half,
    input  logic             idle_lvl,
    output logic             sck,
    output logic             tick
);

    logic [DIV_W-2:0] cnt_q;

    assign tick = run && (cnt_q == half - (DIV_W-1)'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sck   <= 1'b0;
        end else if (start) begin
            cnt_q <= '0;
            sck   <= idle_lvl;
        end else if (run) begin
            if (tick) begin
                cnt_q <= '0;
                sck   <= ~sck;
            end else begin
                cnt_q <= cnt_q + (DIV_W-1)'(1);
            end
        end else begin
            cnt_q <= '0;
            sck   <= idle_lvl;
        end
    end

    // R2: between edges SCK is steady
    p_sck_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(sck));

    // R2: outside a frame SCK goes to the idle level
    p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> (sck == $past(idle_lvl)));

    // R2: half-period counter stays within the programmed half period
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < half));

endmodule

// File: rtl/spi_shift_path.sv
module spi_shift_path #(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [LEN_W-1:0]  load_bits,
    input  logic              load_lsb,
    input  logic              shift_out,
    input  logic              sample,
    input  logic              capture,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_word
);

    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] rx_next;
    logic [DATA_W-1:0] rx_fin;
    logic [DATA_W-1:0] rx_aligned;
    logic [LEN_W-1:0]  bits_q;
    logic              lsb_q;
    logic [LEN_W-1:0]  load_pad;
    logic [LEN_W-1:0]  fin_pad;

    assign load_pad   = LEN_W'(DATA_W) - load_bits;
    assign fin_pad    = LEN_W'(DATA_W) - bits_q;
    assign mosi       = lsb_q ? tx_q[0] : tx_q[DATA_W-1];
    assign rx_next    = lsb_q ? {miso, rx_q[DATA_W-1:1]} : {rx_q[DATA_W-2:0], miso};
    assign rx_fin     = sample ? rx_next : rx_q;
    assign rx_aligned = lsb_q ? (rx_fin >> fin_pad) : rx_fin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q   <= '0;
            rx_q   <= '0;
            bits_q <= LEN_W'(8);
            lsb_q  <= 1'b0;
        end else if (load) begin
            tx_q   <= load_lsb ? load_data : (load_data << load_pad);
            rx_q   <= '0;
            bits_q <= load_bits;
            lsb_q  <= load_lsb;
        end else begin
            if (shift_out)
                tx_q <= lsb_q ? (tx_q >> 1) : (tx_q << 1);
            if (sample)
                rx_q <= rx_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rx_word <= '0;
        else if (capture)
            rx_word <= rx_aligned;
    end

    // R7: transmit word only moves on an accepted write or a shift edge
    p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift_out) |=> $stable(tx_q));

    // R5: readback holds between completions
    p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rx_word));

endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
    import spi_master_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_len_en,
    input  logic [3:0]        cfg_len_code,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lsb_first,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_data
);

    localparam int LEN_W  = $clog2(DATA_W + 1);
    localparam int EDGE_W = LEN_W + 1;

    spi_state_e state_q, state_d;

    logic              accept;
    logic              tick;
    logic              run;
    logic              last_edge;
    logic              leading;
    logic              trailing;
    logic              shift_out;
    logic              sample;
    logic              idle_lvl;
    logic [EDGE_W-1:0] edge_q;
    logic [EDGE_W-1:0] last_idx;
    logic [LEN_W-1:0]  n_in;
    logic [LEN_W-1:0]  n_q;
    logic [DIV_W-1:0]  div_eff;
    logic [DIV_W-2:0]  half_q;
    logic              cpol_q;
    logic              cpha_q;

    assign n_in     = LEN_W'(frame_bits(cfg_len_en, cfg_len_code));
    assign div_eff  = (cfg_div < DIV_W'(8)) ? DIV_W'(8) : cfg_div;
    assign accept   = wr_en && (state_q != S_RUN);
    assign run      = (state_q == S_RUN);
    assign idle_lvl = run ? cpol_q : cfg_cpol;
    assign last_idx = {n_q, 1'b0} - EDGE_W'(1);

    assign last_edge = tick && (edge_q == last_idx);
    assign leading   = tick && !edge_q[0];
    assign trailing  = tick &&  edge_q[0];
    assign shift_out = cpha_q ? (leading && (edge_q != '0)) : (trailing && !last_edge);
    assign sample    = cpha_q ? trailing : leading;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // Transitions: start, last-edge, restart, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept) state_d = S_RUN;
            S_RUN:    if (last_edge) state_d = S_FINISH;
            S_FINISH: state_d = accept ? S_RUN : S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            S_IDLE:   ;
            S_RUN:    busy = 1'b1;
            S_FINISH: done = 1'b1;
            default:  ;
        endcase
    end

    // Frame configuration copy and edge counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= '0;
            n_q    <= LEN_W'(8);
            half_q <= (DIV_W-1)'(4);
            cpol_q <= 1'b0;
            cpha_q <= 1'b0;
        end else if (accept) begin
            edge_q <= '0;
            n_q    <= n_in;
            half_q <= div_eff[DIV_W-1:1];
            cpol_q <= cfg_cpol;
            cpha_q <= cfg_cpha;
        end else if (tick) begin
            edge_q <= edge_q + EDGE_W'(1);
        end
    end

    spi_sck_gen #(.DIV_W(DIV_W)) i_sck_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .run      (run),
        .half     (half_q),
        .idle_lvl (idle_lvl),
        .sck      (sck),
        .tick     (tick)
    );

    spi_shift_path #(.DATA_W(DATA_W), .LEN_W(LEN_W)) i_shift_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (wr_data),
        .load_bits (n_in),
        .load_lsb  (cfg_lsb_first),
        .shift_out (shift_out),
        .sample    (sample),
        .capture   (last_edge),
        .miso      (miso),
        .mosi      (mosi),
        .rx_word   (rx_data)
    );

    // R6: completion strobe lasts one cycle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: bits at and above N read zero at completion
    p_rx_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((rx_data >> n_q) == '0));

    // R1: frame size within 8..16 during a frame
    p_len_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((n_q >= LEN_W'(8)) && (n_q <= LEN_W'(16))));

    // R7: a write during a frame does not restart the edge count
    p_wr_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && !tick) |=> $stable(edge_q));

endmodule

// File: tb/test_spi_shift_master.sv
module test_spi_shift_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_len_en = 1'b0;
    logic [3:0]  cfg_len_code = 4'd0;
    logic        cfg_cpol = 1'b0;
    logic        cfg_cpha = 1'b0;
    logic        cfg_lsb_first = 1'b0;
    logic [7:0]  cfg_div = 8'd8;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'd0;
    logic        miso = 1'b0;
    logic        sck;
    logic        mosi;
    logic        busy;
    logic        done;
    logic [15:0] rx_data;

    int n_checks = 0;
    int n_fail = 0;
    logic [15:0] last_rx = 16'd0;

    always #2 clk = ~clk;

    spi_shift_master i_spi_shift_master (
        .clk(clk), .rst_n(rst_n), .cfg_len_en(cfg_len_en), .cfg_len_code(cfg_len_code),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
        .cfg_div(cfg_div), .wr_en(wr_en), .wr_data(wr_data), .miso(miso),
        .sck(sck), .mosi(mosi), .busy(busy), .done(done), .rx_data(rx_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int bit_pos(input int i, input int n, input bit lsb);
        return lsb ? i : n - 1 - i;
    endfunction

    task automatic run_frame(input bit en, input logic [3:0] code, input bit cpol, input bit cpha,
                             input bit lsb, input int div, input logic [15:0] txd,
                             input logic [15:0] sw, input bit inject);
        int n, d, c, ecnt, mask;
        bit prev;
        logic [15:0] cap;
        @(negedge clk);
        cfg_len_en = en; cfg_len_code = code; cfg_cpol = cpol; cfg_cpha = cpha;
        cfg_lsb_first = lsb; cfg_div = 8'(div);
        @(negedge clk);
        @(negedge clk);
        check(sck == cpol, "R2 idle level", int'(sck), int'(cpol));
        // R1: expected frame size
        n = !en ? 8 : (code == 4'd0 ? 16 : (code[3] ? int'(code) : 8));
        d = (div < 8) ? 8 : (div & ~1);
        mask = (1 << n) - 1;
        cap = 16'd0;
        miso = sw[bit_pos(0, n, lsb)];
        wr_en = 1'b1; wr_data = txd;
        @(negedge clk);
        wr_en = 1'b0;
        c = 0; ecnt = 0; prev = cpol;
        check(busy == 1'b1, "R6 busy after write", int'(busy), 1);
        check(rx_data == last_rx, "R5 readback held", int'(rx_data), int'(last_rx));
        while (c < 20000) begin
            if (inject && c == d) begin wr_en = 1'b1; wr_data = ~txd; end
            if (inject && c == d + 1) wr_en = 1'b0;
            if (sck != prev) begin
                int i;
                i = ecnt / 2;
                if (ecnt % 2 == 0) begin
                    // R2: leading edge at D/2*(k+1)
                    check(c == (d / 2) * (ecnt + 1), "R2 edge time", c, (d / 2) * (ecnt + 1));
                    if (!cpha) cap[bit_pos(i, n, lsb)] = mosi;
                    else miso = sw[bit_pos(i, n, lsb)];
                end else begin
                    if (cpha) cap[bit_pos(i, n, lsb)] = mosi;
                    else if (i + 1 < n) miso = sw[bit_pos(i + 1, n, lsb)];
                end
                prev = sck;
                ecnt++;
            end
            if (done) break;
            @(negedge clk);
            c++;
        end
        wr_en = 1'b0;
        check(c == n * d, "R6 done time", c, n * d);
        check(busy == 1'b0, "R6 busy low at done", int'(busy), 0);
        check(ecnt == 2 * n, "R2 edge count", ecnt, 2 * n);
        // R3 and R4: serial data order and phase, R7: injected write had no effect
        check(cap == (txd & 16'(mask)), "R3 R4 R7 mosi word", int'(cap), int'(txd & 16'(mask)));
        check(rx_data == (sw & 16'(mask)), "R5 R3 R4 rx word", int'(rx_data), int'(sw & 16'(mask)));
        last_rx = sw & 16'(mask);
        @(negedge clk);
        check(done == 1'b0, "R6 done pulse width", int'(done), 0);
        check(sck == cpol, "R2 idle after frame", int'(sck), int'(cpol));
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check(sck == 1'b0, "R8 sck", int'(sck), 0);
        check(busy == 1'b0, "R8 busy", int'(busy), 0);
        check(done == 1'b0, "R8 done", int'(done), 0);
        check(rx_data == 16'd0, "R8 rx_data", int'(rx_data), 0);
        rst_n = 1'b1;
        // R1 sweep over all codes, modes and orders
        for (int code = 0; code < 16; code++) begin
            for (int mode = 0; mode < 4; mode++) begin
                for (int lsb = 0; lsb < 2; lsb++) begin
                    run_frame(1'b1, 4'(code), mode[1], mode[0], lsb[0], 8,
                              16'hA5C3 ^ 16'(code * 16'h1111) ^ 16'(mode * 16'h0F0F),
                              16'h3C96 ^ 16'(code * 16'h0707) ^ 16'(lsb * 16'hFFFF),
                              lsb[0]);
                end
            end
        end
        // R1: length-enable 0 forces 8 bits
        run_frame(1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 8, 16'hFFAB, 16'h1234, 1'b1);
        run_frame(1'b0, 4'hC, 1'b1, 1'b1, 1'b1, 8, 16'h5A5A, 16'hC3C3, 1'b0);
        // R2: divider variants
        run_frame(1'b1, 4'd0, 1'b0, 1'b1, 1'b0, 10, 16'hBEEF, 16'hCAFE, 1'b1);
        run_frame(1'b1, 4'hA, 1'b1, 1'b0, 1'b1, 13, 16'h0357, 16'h02A9, 1'b0);
        run_frame(1'b1, 4'h9, 1'b0, 1'b0, 1'b0, 4, 16'h01FF, 16'h0155, 1'b0);
        run_frame(1'b1, 4'd0, 1'b1, 1'b1, 1'b0, 255, 16'h8001, 16'h7FFE, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule